// File: doc/BRIEF.md
# Serial Potentiometer Register Decoder

This block is the digital front end of a 128-position digital potentiometer. It acts as an SPI mode 0 slave and accepts fixed three-byte frames while chip select is low. Each frame carries a fixed identification byte, an instruction byte holding an opcode and a register pointer, and a data byte. A valid write changes a register only when chip select rises after exactly 24 bits. A valid read returns the addressed register on the serial output during the third byte.

The register set has three entries. The first is a volatile wiper code that drives the resistor array. The second is a local copy of the power-up (initial-value) code, which shares the wiper's pointer. The third is a control register. Its top bit is a target-select bit. When that bit is 1, the shared pointer reaches only the wiper. When it is 0, the shared pointer reaches the initial-value copy, and a write also loads the wiper and sends a store request to a separate non-volatile controller.

The serial clock, chip select and data input are brought into the system clock domain through two-stage synchronizers. All edge detection happens in the system clock domain.

Top module: `spi_pot_ctrl`

## Requirements
- R1: Input bits are taken on rising serial-clock edges, most significant bit first. On a read, the output enable turns on at the first falling edge after the 16th rising edge. The addressed byte is then shifted out most significant bit first, one bit per falling edge.
- R2: A frame is byte 0 = 0x50, then byte 1 = {opcode[7:4], 2'b00, pointer[1:0]}, then the data byte. Opcode 1100 is a write and opcode 1011 is a read. A write takes effect when chip select rises after exactly 24 bits.
- R3: While control bit 7 is 1, a write to pointer 00 loads only the wiper (data bits 6:0) and raises no store request. A read of pointer 00 returns {0, wiper}.
- R4: While control bit 7 is 0, a write to pointer 00 loads both the wiper and the initial-value copy. It also pulses nv_wr_en for one clock with nv_wr_data equal to the new code. A read of pointer 00 returns {0, initial value} and leaves the wiper unchanged.
- R5: Pointer 10 is the control register. Bits 7 and 6 are writable, with reset values 0 and 1. Bit 5 reads nv_busy. Bits 4:0 read 0, so the value read after reset is 0x40.
- R6: After reset, the wiper and the initial-value copy hold RESET_CODE (64), sdo_oe is 0 and nv_wr_en is 0.
- R7: A frame with a wrong identification byte, an opcode other than 1011 or 1100, pointer 01 or 11, or instruction bits 3:2 not zero changes no register, raises no store request, and never enables the serial output.
- R8: A write frame of fewer or more than 24 bits changes no register.
- R9: Serial activity before the first falling edge of chip select after reset is ignored.
- R10: The serial output is disabled whenever chip select is high. After chip select rises, sdo_oe falls within a few system clocks.
- R11: A read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from the host |
| nv_busy | input | 1 | Store controller busy, read as control bit 5 |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Output enable for the open-drain pad driver |
| nv_wr_en | output | 1 | One-clock store request to the non-volatile controller |
| nv_wr_data | output | CODE_W | Code to store |
| wiper_code | output | CODE_W | Current wiper position |

## Verification
The assertions assume that the serial clock is at least several system clocks per phase, so that every serial edge reaches the synchronized domain as a separate edge. They also assume that the data input is stable across each rising edge, and that nv_busy is synchronous to clk. The bench drives each serial phase for six system clocks and changes the data input only while the serial clock is low. It samples the output just before each rising edge. It sweeps every wiper code, every opcode value, each pointer pattern and the short and long frame lengths, and it computes each expected value from the requirements.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
  localparam int FRAME_BITS = 24;
  localparam logic [7:0] ID_BYTE  = 8'h50;
  localparam logic [3:0] OP_READ  = 4'b1011;
  localparam logic [3:0] OP_WRITE = 4'b1100;
  localparam logic [1:0] PTR_CODE = 2'b00;
  localparam logic [1:0] PTR_CTRL = 2'b10;

  typedef enum logic [1:0] {TGT_NONE, TGT_CODE, TGT_CTRL} tgt_e;

  typedef struct packed {
    logic is_read;
    logic is_write;
    tgt_e tgt;
  } cmd_t;

  function automatic cmd_t decode_instr(input logic [7:0] b);
    cmd_t c;
    tgt_e t;
    if (b[3:2] != 2'b00)         t = TGT_NONE;
    else if (b[1:0] == PTR_CODE) t = TGT_CODE;
    else if (b[1:0] == PTR_CTRL) t = TGT_CTRL;
    else                         t = TGT_NONE;
    c.tgt      = t;
    c.is_read  = (b[7:4] == OP_READ)  && (t != TGT_NONE);
    c.is_write = (b[7:4] == OP_WRITE) && (t != TGT_NONE);
    return c;
  endfunction
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_pot_frame.sv
module spi_pot_frame
  import spi_pot_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_s,
  input  logic             cs_n_s,
  input  logic             sdi_s,
  output logic             sck_fall,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             rd_go,
  output tgt_e             cur_tgt,
  output logic             commit,
  output tgt_e             commit_tgt,
  output logic [7:0]       commit_data
);
  localparam logic [CNT_W-1:0] CNT_ID_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] CNT_INS_LAST = CNT_W'(15);
  localparam logic [CNT_W-1:0] CNT_DAT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER     = CNT_W'(FRAME_BITS + 1);

  logic       sck_d, cs_d;
  logic       sck_rise, cs_fall, cs_rise;
  logic       armed, id_ok;
  logic [7:0] shreg, next_byte;
  cmd_t       cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_d;
  assign sck_fall  = ~sck_s & sck_d;
  assign cs_fall   = ~cs_n_s & cs_d;
  assign cs_rise   = cs_n_s & ~cs_d;
  assign next_byte = {shreg[6:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      id_ok       <= 1'b0;
      cmd_q       <= '0;
      commit      <= 1'b0;
      commit_tgt  <= TGT_NONE;
      commit_data <= '0;
    end else begin
      commit <= 1'b0;
      if (cs_fall) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
        id_ok   <= 1'b0;
        cmd_q   <= '0;
      end else if (cs_rise) begin
        if (armed && bit_cnt == CNT_FULL && id_ok && cmd_q.is_write) begin
          commit     <= 1'b1;
          commit_tgt <= cmd_q.tgt;
        end
      end else if (armed && !cs_n_s && sck_rise) begin
        shreg <= next_byte;
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_ID_LAST)  id_ok <= (next_byte == ID_BYTE);
        if (bit_cnt == CNT_INS_LAST) cmd_q <= decode_instr(next_byte);
        if (bit_cnt == CNT_DAT_LAST) commit_data <= next_byte;
      end
    end
  end

  assign rd_go   = id_ok & cmd_q.is_read;
  assign cur_tgt = cmd_q.tgt;

  // R2: a commit only follows a frame of exactly the full bit count
  assert_commit_full_frame_R2: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(bit_cnt) == CNT_FULL);
  // R8: the bit counter saturates one past the frame length
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_OVER);
  // R9: nothing is counted before chip select has fallen once
  assert_idle_until_armed_R9: assert property (@(posedge clk) disable iff (rst)
    !armed |-> bit_cnt == '0 && !commit);
endmodule

// File: rtl/spi_pot_regs.sv
module spi_pot_regs
  import spi_pot_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int RESET_CODE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  tgt_e              commit_tgt,
  input  logic [7:0]        commit_data,
  input  tgt_e              rd_tgt,
  input  logic              nv_busy,
  output logic [7:0]        rd_data,
  output logic [CODE_W-1:0] wiper_q,
  output logic              nv_wr_en,
  output logic [CODE_W-1:0] nv_wr_data
);
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(RESET_CODE);
  localparam int PAD_W = 8 - CODE_W;

  logic [CODE_W-1:0] init_q;
  logic              vol_q, run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_q    <= RST_CODE;
      init_q     <= RST_CODE;
      vol_q      <= 1'b0;
      run_q      <= 1'b1;
      nv_wr_en   <= 1'b0;
      nv_wr_data <= RST_CODE;
    end else begin
      nv_wr_en <= 1'b0;
      if (commit) begin
        case (commit_tgt)
          TGT_CTRL: begin
            vol_q <= commit_data[7];
            run_q <= commit_data[6];
          end
          TGT_CODE: begin
            wiper_q <= commit_data[CODE_W-1:0];
            if (!vol_q) begin
              init_q     <= commit_data[CODE_W-1:0];
              nv_wr_en   <= 1'b1;
              nv_wr_data <= commit_data[CODE_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_tgt)
      TGT_CTRL: rd_data = {vol_q, run_q, nv_busy, 5'b00000};
      TGT_CODE: rd_data = vol_q ? {{PAD_W{1'b0}}, wiper_q} : {{PAD_W{1'b0}}, init_q};
      default:  rd_data = 8'h00;
    endcase
  end

  // R7 / R11: registers only move on a commit
  assert_quiet_without_commit_R7: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(wiper_q) && $stable(init_q) && $stable(vol_q) && $stable(run_q));
  // R4: a store request carries the code the wiper now holds
  assert_store_matches_wiper_R4: assert property (@(posedge clk) disable iff (rst)
    nv_wr_en |-> wiper_q == nv_wr_data);
  // R3: a store request never lasts more than one clock
  assert_store_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    nv_wr_en |=> !nv_wr_en);
endmodule

// File: rtl/spi_pot_tx.sv
module spi_pot_tx #(
  parameter int CNT_W = 5,
  parameter int FRAME_BITS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_s,
  input  logic             sck_fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             rd_go,
  input  logic [7:0]       rd_data,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_BITS - 8);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      sdo_oe <= 1'b0;
    end else if (cs_n_s) begin
      sdo_oe <= 1'b0;
    end else if (sck_fall) begin
      if (bit_cnt == CNT_HDR && rd_go) begin
        sh     <= rd_data;
        sdo_oe <= 1'b1;
      end else if (bit_cnt > CNT_FULL) begin
        sdo_oe <= 1'b0;
      end else if (sdo_oe && bit_cnt > CNT_HDR && bit_cnt < CNT_FULL) begin
        sh <= {sh[6:0], 1'b0};
      end
    end
  end

  assign sdo = sh[7];

  // R10: a deselected slave releases the output on the next clock
  assert_released_when_deselected_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !sdo_oe);
  // R1: driving starts only once the header bytes are in
  assert_drive_after_header_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(bit_cnt) == CNT_HDR);
endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl
  import spi_pot_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int RESET_CODE = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  input  logic              nv_busy,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              nv_wr_en,
  output logic [CODE_W-1:0] nv_wr_data,
  output logic [CODE_W-1:0] wiper_code
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic [2:0]       raw_in, sync_out;
  logic             sck_s, cs_n_s, sdi_s;
  logic             sck_fall, rd_go, commit;
  logic [CNT_W-1:0] bit_cnt;
  tgt_e             cur_tgt, commit_tgt;
  logic [7:0]       commit_data, rd_data;

  assign raw_in = {spi_sck, spi_cs_n, spi_sdi};

  spi_pot_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign {sck_s, cs_n_s, sdi_s} = sync_out;

  spi_pot_frame #(.CNT_W(CNT_W)) frame_i (
    .clk(clk), .rst(rst), .sck_s(sck_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
    .sck_fall(sck_fall), .bit_cnt(bit_cnt), .rd_go(rd_go), .cur_tgt(cur_tgt),
    .commit(commit), .commit_tgt(commit_tgt), .commit_data(commit_data)
  );

  spi_pot_regs #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) regs_i (
    .clk(clk), .rst(rst), .commit(commit), .commit_tgt(commit_tgt),
    .commit_data(commit_data), .rd_tgt(cur_tgt), .nv_busy(nv_busy),
    .rd_data(rd_data), .wiper_q(wiper_code), .nv_wr_en(nv_wr_en),
    .nv_wr_data(nv_wr_data)
  );

  spi_pot_tx #(.CNT_W(CNT_W), .FRAME_BITS(FRAME_BITS)) tx_i (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_fall(sck_fall),
    .bit_cnt(bit_cnt), .rd_go(rd_go), .rd_data(rd_data),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );
endmodule

// File: tb/spi_pot_ctrl_tb.sv
module spi_pot_ctrl_tb_top;
  localparam int HALF = 6;
  localparam logic [7:0] ID = 8'h50;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b0, sdi = 1'b0, nv_busy = 1'b0;
  logic sdo, sdo_oe, nv_wr_en;
  logic [6:0] nv_wr_data, wiper_code;
  int total = 0, bad = 0, nv_cnt = 0;
  logic [6:0] nv_last = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spi_pot_ctrl dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .nv_busy(nv_busy), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
    .nv_wr_en(nv_wr_en), .nv_wr_data(nv_wr_data), .wiper_code(wiper_code)
  );

  always @(posedge clk) if (!rst && nv_wr_en) begin
    nv_cnt <= nv_cnt + 1;
    nv_last <= nv_wr_data;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] pat, input int nbits,
                      output logic [7:0] rd, output bit oe_any, output bit oe_all);
    rd = '0; oe_any = 1'b0; oe_all = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = pat[31-i];
      repeat (HALF) @(negedge clk);
      if (sdo_oe) oe_any = 1'b1;
      if (i >= 16 && i < 24) begin
        rd = {rd[6:0], sdo};
        if (!sdo_oe) oe_all = 1'b0;
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] op, input logic [3:0] low, input logic [7:0] d);
    logic [7:0] r; bit a, b;
    xfer({ID, op, low, d, 8'h00}, 24, r, a, b);
  endtask

  task automatic rd(input logic [1:0] ptr, output logic [7:0] v, output bit oe_all);
    bit a;
    xfer({ID, 4'b1011, 2'b00, ptr, 8'h00, 8'h00}, 24, v, a, oe_all);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v; bit all, any;
    int n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(wiper_code == 7'd64, "R6 reset wiper", wiper_code, 64);
    chk(!sdo_oe, "R6 reset sdo_oe", sdo_oe, 0);
    chk(!nv_wr_en && nv_cnt == 0, "R6 reset store", nv_cnt, 0);

    // R9: chip select low since reset, no falling edge yet
    xfer({ID, 4'b1100, 4'b0000, 8'h11, 8'h00}, 24, v, any, all);
    chk(wiper_code == 7'd64, "R9 ignored before first select", wiper_code, 64);
    chk(nv_cnt == 0, "R9 no store before first select", nv_cnt, 0);

    // R5: control register after reset and with busy
    rd(2'b10, v, all);
    chk(v == 8'h40 && all, "R5 control reset read", v, 8'h40);
    nv_busy = 1'b1;
    rd(2'b10, v, all);
    chk(v == 8'h60, "R5 busy bit read", v, 8'h60);
    nv_busy = 1'b0;
    chk(!sdo_oe, "R10 released after read", sdo_oe, 0);

    // R4: write through to initial value
    wr(4'b1100, 4'b0000, 8'h77);
    chk(wiper_code == 7'h77, "R4 wiper follows store write", wiper_code, 8'h77);
    chk(nv_cnt == 1 && nv_last == 7'h77, "R4 store request", nv_last, 8'h77);
    rd(2'b00, v, all);
    chk(v == 8'h77 && all, "R4 R1 read initial value", v, 8'h77);

    // R5: control writes, bits 4:0 read zero
    wr(4'b1100, 4'b0010, 8'hFF);
    rd(2'b10, v, all);
    chk(v == 8'hC0, "R5 control write all ones", v, 8'hC0);
    wr(4'b1100, 4'b0010, 8'h80);
    rd(2'b10, v, all);
    chk(v == 8'h80, "R5 control shutdown bit clear", v, 8'h80);

    // R3 / R1: sweep every wiper code in volatile mode
    for (int c = 0; c < 128; c++) begin
      wr(4'b1100, 4'b0000, {~c[0], c[6:0]});
      chk(wiper_code == c[6:0], "R3 sweep wiper", wiper_code, c);
      rd(2'b00, v, all);
      chk(v == {1'b0, c[6:0]} && all, "R3 R1 sweep readback", v, c);
    end
    chk(nv_cnt == 1, "R3 no store in volatile mode", nv_cnt, 1);

    // R4 / R11: back to store mode, read the initial copy
    wr(4'b1100, 4'b0010, 8'h40);
    rd(2'b00, v, all);
    chk(v == 8'h77, "R4 initial copy kept", v, 8'h77);
    chk(wiper_code == 7'h7F, "R11 read leaves wiper", wiper_code, 8'h7F);

    // R7: every invalid opcode, as write and read patterns
    for (int op = 0; op < 16; op++) begin
      if (op == 11 || op == 12) continue;
      xfer({ID, op[3:0], 4'b0000, 8'h05, 8'h00}, 24, v, any, all);
      chk(wiper_code == 7'h7F && nv_cnt == 1 && !any, "R7 bad opcode ignored", wiper_code, 8'h7F);
    end
    xfer({8'h51, 4'b1100, 4'b0000, 8'h05, 8'h00}, 24, v, any, all);
    chk(wiper_code == 7'h7F && nv_cnt == 1, "R7 bad id write", wiper_code, 8'h7F);
    xfer({8'hD0, 4'b1011, 4'b0000, 8'h00, 8'h00}, 24, v, any, all);
    chk(!any, "R7 bad id read silent", any, 0);
    xfer({ID, 4'b1011, 4'b0001, 8'h00, 8'h00}, 24, v, any, all);
    chk(!any, "R7 pointer 01 read silent", any, 0);
    wr(4'b1100, 4'b0011, 8'hC0);
    wr(4'b1100, 4'b0110, 8'hC0);
    wr(4'b1100, 4'b0001, 8'h05);
    rd(2'b10, v, all);
    chk(v == 8'h40, "R7 bad pointers leave control", v, 8'h40);
    chk(wiper_code == 7'h7F && nv_cnt == 1, "R7 bad pointers leave wiper", wiper_code, 8'h7F);

    // R8: short and long frames
    n0 = nv_cnt;
    xfer({ID, 4'b1100, 4'b0000, 8'h33, 8'h00}, 23, v, any, all);
    chk(wiper_code == 7'h7F, "R8 short frame ignored", wiper_code, 8'h7F);
    xfer({ID, 4'b1100, 4'b0000, 8'h33, 8'h00}, 25, v, any, all);
    chk(wiper_code == 7'h7F, "R8 long frame ignored", wiper_code, 8'h7F);
    chk(nv_cnt == n0, "R8 no store from bad length", nv_cnt, n0);

    // R2: a full valid frame still works after the rejects
    wr(4'b1100, 4'b0000, 8'h2A);
    chk(wiper_code == 7'h2A && nv_last == 7'h2A, "R2 valid write after rejects", wiper_code, 8'h2A);
    chk(!sdo_oe, "R10 idle output released", sdo_oe, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule